// File: doc/BRIEF.md
# Eight-bit timer with compare-match flags

This block is an 8-bit up-counting timer that a processor configures through a small register file. A free-running prescaler produces a count enable at one of several rates chosen by a 3-bit clock-select field. On each count, or on a direct software write to the counter, the new counter value is compared against two compare registers. Matches and overflows set sticky flags.

A waveform-mode field decides two things: whether a wrap past the maximum value is flagged, and whether a compare-A match clears the counter. The mode bits are split over two control registers. Flags that are unmasked raise one interrupt request line at a time, in a fixed priority, while a global enable input is high. An acknowledge pulse retires the request being shown. Software can also clear any flag by writing a one to it.

Register addresses: 0 counter, 1 compare A, 2 compare B, 3 control A, 4 control B, 5 flags, 6 mask.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset every register reads 0. The registers sit at addresses 0 counter, 1 compare A, 2 compare B, 3 control A, 4 control B, 5 flags (bits 2:0) and 6 mask (bits 2:0). Reads are combinational, and address 7 reads 0.
- R2: The clock select is control B bits 2:0. A 10-bit prescaler counts every cycle from reset. The counter advances when clock select is 1 (every cycle), 2 (prescaler bits 2:0 all ones), 3 (bits 5:0 all ones), 4 (bits 7:0 all ones) or 5 (all 10 bits ones). Values 0, 6 and 7 hold the counter.
- R3: The mode is {control B bit 3, control A bits 1:0}. In modes 0, 1 and 3, an advance from 255 to 0 sets flag bit 0 (overflow). In every other mode, including mode 2, a wrap sets no flag.
- R4: When the counter's new value equals a nonzero compare A, flag bit 1 is set. In mode 2 the counter is loaded with 0 instead, and flag bit 0 is also set.
- R5: When the counter's new value equals a nonzero compare B, flag bit 2 is set. In mode 2 this test uses the value before any clear.
- R6: A compare register holding 0 never matches. A match uses the compare values held before a write in the same cycle.
- R7: A write to the counter takes priority over a count in the same cycle. The written value is compared exactly as an advanced value would be.
- R8: Writing to address 5 clears each flag whose data bit is 1. A flag set by hardware in the same cycle stays set.
- R9: irq_req is one-hot or zero. It shows the lowest-numbered flag that is set and unmasked, and only while gie is high. Bit 0 is overflow, bit 1 compare A and bit 2 compare B.
- R10: irq_ack clears the flag whose request is shown in that cycle. A hardware set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Acknowledge of the shown request |
| irq_req | output | 3 | Interrupt request, one-hot |

## Verification
The assertions assume that irq_ack is only a pulse for the request currently shown. They also assume that writes arrive through the one write port, so a counter change not caused by the prescaler or a write means an error. The stimulus drives every input at the falling edge from one bench model. It raises irq_ack at random whether or not a request is pending, which the design must treat as having no effect when nothing is shown. Writes are kept sparse, so the counter runs long enough to wrap and match between reconfigurations.

// File: rtl/tmr8_cmp.sv
module tmr8_cmp #(
  parameter int W     = 8,
  parameter int PRE_W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         gie,
  input  logic         irq_ack,
  output logic [2:0]   irq_req
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0]     cnt_q, cmpa_q, cmpb_q, ctla_q, ctlb_q;
  logic [2:0]       flag_q, mask_q;
  logic [PRE_W-1:0] pre_q;

  logic [2:0]   mode, cs;
  logic         tick, wrap_ok;
  logic [W-1:0] cand, cnt_d;
  logic         upd;
  logic [2:0]   hw_set, clr, pend;

  assign mode    = {ctlb_q[3], ctla_q[1:0]};
  assign cs      = ctlb_q[2:0];
  assign wrap_ok = (mode == 3'd0) || (mode == 3'd1) || (mode == 3'd3);

  always_comb begin
    case (cs)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre_q[2:0];
      3'd3:    tick = &pre_q[5:0];
      3'd4:    tick = &pre_q[7:0];
      3'd5:    tick = &pre_q[9:0];
      default: tick = 1'b0;
    endcase
  end

  always_comb begin
    hw_set = 3'b000;
    upd    = 1'b0;
    cand   = cnt_q;
    if (wr_en && wr_addr == 3'd0) begin
      cand = wr_data;
      upd  = 1'b1;
    end else if (tick) begin
      cand = cnt_q + 1'b1;
      upd  = 1'b1;
      if (cnt_q == MAXV && wrap_ok) hw_set[0] = 1'b1;
    end
    cnt_d = cand;
    if (upd && cmpa_q != '0 && cand == cmpa_q) begin
      hw_set[1] = 1'b1;
      if (mode == 3'd2) begin
        cnt_d     = '0;
        hw_set[0] = 1'b1;
      end
    end
    if (upd && cmpb_q != '0 && cand == cmpb_q) hw_set[2] = 1'b1;
  end

  assign pend    = gie ? (flag_q & mask_q) : 3'b000;
  assign irq_req = pend[0] ? 3'b001 : pend[1] ? 3'b010 : pend[2] ? 3'b100 : 3'b000;
  assign clr     = ((wr_en && wr_addr == 3'd5) ? wr_data[2:0] : 3'b000)
                 | (irq_ack ? irq_req : 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      ctla_q <= '0;
      ctlb_q <= '0;
      flag_q <= '0;
      mask_q <= '0;
      pre_q  <= '0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      cnt_q  <= cnt_d;
      flag_q <= (flag_q & ~clr) | hw_set;
      if (wr_en) begin
        case (wr_addr)
          3'd1:    cmpa_q <= wr_data;
          3'd2:    cmpb_q <= wr_data;
          3'd3:    ctla_q <= wr_data;
          3'd4:    ctlb_q <= wr_data;
          3'd6:    mask_q <= wr_data[2:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = cnt_q;
      3'd1:    rd_data = cmpa_q;
      3'd2:    rd_data = cmpb_q;
      3'd3:    rd_data = ctla_q;
      3'd4:    rd_data = ctlb_q;
      3'd5:    rd_data = {{(W-3){1'b0}}, flag_q};
      3'd6:    rd_data = {{(W-3){1'b0}}, mask_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr8_cmp_chk.sv
module tmr8_cmp_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic         gie,
  input logic         irq_ack,
  input logic [2:0]   irq_req,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmpa,
  input logic [W-1:0] cmpb,
  input logic [2:0]   mode,
  input logic [2:0]   cs,
  input logic [2:0]   flags
);
  p_req_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_req));

  p_req_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> irq_req == 3'b000);

  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs == 3'd0 || cs >= 3'd6) && !(wr_en && wr_addr == 3'd0)) |=> $stable(cnt));

  p_ctc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && wr_en && wr_addr == 3'd0 && cmpa != '0 && wr_data == cmpa)
    |=> (cnt == '0 && flags[1] && flags[0]));

  p_zero_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpb == '0 && !flags[2] && !(wr_en && wr_addr == 3'd5)) |=> !flags[2]);

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req == 3'b001 && cs == 3'd0 && !wr_en) |=> !flags[0]);
endmodule

bind tmr8_cmp tmr8_cmp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .gie(gie), .irq_ack(irq_ack), .irq_req(irq_req), .cnt(cnt_q), .cmpa(cmpa_q),
  .cmpb(cmpb_q), .mode(mode), .cs(cs), .flags(flag_q)
);

// File: tb/tmr8_cmp_tb.sv
`timescale 1ns/1ps
module tmr8_cmp_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       gie = 1'b0;
  logic       irq_ack = 1'b0;
  logic [2:0] irq_req;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_cnt, m_ca, m_cb, m_c0, m_c1;
  logic [2:0] m_fl, m_mk;
  logic [9:0] m_pre;

  always #2.5 clk = ~clk;

  tmr8_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .gie(gie), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_ca;
      3'd2: return m_cb;
      3'd3: return m_c0;
      3'd4: return m_c1;
      3'd5: return {5'b0, m_fl};
      3'd6: return {5'b0, m_mk};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] m_req(input logic g);
    logic [2:0] p;
    p = g ? (m_fl & m_mk) : 3'b000;
    if (p[0]) return 3'b001;
    if (p[1]) return 3'b010;
    if (p[2]) return 3'b100;
    return 3'b000;
  endfunction

  function automatic logic m_tick(input logic [2:0] cs, input logic [9:0] pr);
    case (cs)
      3'd1: return 1'b1;
      3'd2: return pr[2:0] == 3'h7;
      3'd3: return pr[5:0] == 6'h3f;
      3'd4: return pr[7:0] == 8'hff;
      3'd5: return pr == 10'h3ff;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_next();
    logic [2:0] md, set, clr;
    logic [7:0] nv;
    logic up;
    md = {m_c1[3], m_c0[1:0]};
    set = 3'b000; up = 1'b0; nv = m_cnt;
    if (wr_en && wr_addr == 3'd0) begin nv = wr_data; up = 1'b1; end
    else if (m_tick(m_c1[2:0], m_pre)) begin
      nv = m_cnt + 8'd1; up = 1'b1;
      if (m_cnt == 8'hff && (md == 3'd0 || md == 3'd1 || md == 3'd3)) set[0] = 1'b1;
    end
    if (up && m_cb != 8'h00 && nv == m_cb) set[2] = 1'b1;
    if (up && m_ca != 8'h00 && nv == m_ca) begin
      set[1] = 1'b1;
      if (md == 3'd2) begin nv = 8'h00; set[0] = 1'b1; end
    end
    clr = ((wr_en && wr_addr == 3'd5) ? wr_data[2:0] : 3'b000) | (irq_ack ? m_req(gie) : 3'b000);
    m_fl = (m_fl & ~clr) | set;
    m_cnt = nv;
    m_pre = m_pre + 10'd1;
    if (wr_en) begin
      case (wr_addr)
        3'd1: m_ca = wr_data;
        3'd2: m_cb = wr_data;
        3'd3: m_c0 = wr_data;
        3'd4: m_c1 = wr_data;
        3'd6: m_mk = wr_data[2:0];
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic we, input logic [2:0] wa, input logic [7:0] wd,
                      input logic [2:0] ra, input logic g, input logic ak);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; gie = g; irq_ack = ak;
    model_next();
    @(negedge clk);
    chk("R1 read", rd_data, m_read(ra));
    chk("R9 irq", {5'b0, irq_req}, {5'b0, m_req(g)});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [2:0] ra);
    step(1'b1, a, d, ra, 1'b0, 1'b0);
  endtask

  task automatic idle(input logic [2:0] ra, input logic g);
    step(1'b0, 3'd0, 8'h00, ra, g, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; irq_ack = 1'b0; gie = 1'b0;
    m_cnt = 0; m_ca = 0; m_cb = 0; m_c0 = 0; m_c1 = 0; m_fl = 0; m_mk = 0; m_pre = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    do_reset();
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #0.1;
      chk("R1 reset", rd_data, 8'h00);
    end

    // R4: CTC clear on compare A
    wr(3'd1, 8'h11, 3'd0); wr(3'd3, 8'h02, 3'd0); wr(3'd0, 8'h10, 3'd0);
    wr(3'd4, 8'h01, 3'd0);
    idle(3'd5, 1'b0); chk("R4 flags", rd_data, 8'h03);
    idle(3'd0, 1'b0); chk("R4 cnt", rd_data, 8'h01);

    // R3, R6: overflow in normal mode with zero compares
    do_reset();
    wr(3'd4, 8'h01, 3'd0); wr(3'd0, 8'hff, 3'd0);
    idle(3'd5, 1'b0); chk("R3 R6 flags", rd_data, 8'h01);
    // R8: hardware set wins over write-one-to-clear
    wr(3'd0, 8'hff, 3'd0);
    wr(3'd5, 8'h01, 3'd5); chk("R8 set wins", rd_data, 8'h01);
    wr(3'd4, 8'h00, 3'd5);
    wr(3'd5, 8'h07, 3'd5); chk("R8 clear", rd_data, 8'h00);

    // R3: no overflow flag on wrap in mode 2
    do_reset();
    wr(3'd3, 8'h02, 3'd0); wr(3'd4, 8'h01, 3'd0); wr(3'd0, 8'hff, 3'd0);
    idle(3'd5, 1'b0); chk("R3 ctc wrap", rd_data, 8'h00);

    // R5, R7: write matches compare B
    do_reset();
    wr(3'd2, 8'h05, 3'd0); wr(3'd0, 8'h05, 3'd5); chk("R5 R7 flags", rd_data, 8'h04);

    // R9, R10: gating, priority, acknowledge
    wr(3'd6, 8'h07, 3'd5);
    wr(3'd4, 8'h01, 3'd5); wr(3'd0, 8'hff, 3'd5);
    wr(3'd4, 8'h00, 3'd5); chk("R3 flags", rd_data, 8'h05);
    chk("R9 gated", {5'b0, irq_req}, 8'h00);
    idle(3'd5, 1'b1); chk("R9 prio", {5'b0, irq_req}, 8'h01);
    step(1'b0, 3'd0, 8'h00, 3'd5, 1'b1, 1'b1); chk("R10 ack", rd_data, 8'h04);
    chk("R9 next", {5'b0, irq_req}, 8'h04);

    // R2: prescaled rate 8
    do_reset();
    wr(3'd4, 8'h02, 3'd0);
    for (int i = 0; i < 40; i++) idle(3'd0, 1'b0);
    chk("R2 div8", rd_data, m_cnt);

    // random mixed traffic
    for (int i = 0; i < 30000; i++) begin
      logic we; logic [2:0] a; logic [7:0] d;
      we = ($urandom % 8) == 0;
      a  = 3'($urandom % 7);
      d  = 8'($urandom);
      if (a == 3'd4) d = ($urandom % 4 != 0) ? {4'b0, d[3], 3'd1} : d;
      if (a == 3'd0 && d[0]) d = 8'hf0 | d;
      if ((a == 3'd1 || a == 3'd2) && ($urandom % 4 == 0)) d = 8'h00;
      step(we, a, d, 3'($urandom), ($urandom % 4) != 0, ($urandom % 3) == 0);
    end
    chk("R2 final cnt", m_read(3'd0), m_cnt);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule